// File: doc/BRIEF.md
# Indirect Flash Access Controller

This block lets a debug or programming port reach on-chip nonvolatile memory through a small bank of byte-wide host registers. The registers are a control byte, a 17-bit address split over three byte registers, a data byte and a read-only status byte. The host never addresses the memory directly. Loading or reading the data register is what moves bytes to or from the array, and the control byte decides which side effect each access has.

On the memory side the controller issues a one-cycle request that carries an operation code, an address, a scratchpad flag and a write byte. It then stays busy until the memory returns a one-cycle done pulse, and on a read that pulse comes with the fetched byte. Writes to the data register can just hold the byte, program it and step the address, or erase a page when the key byte 0xA5 is written. An erase aimed at a reserved address clears the whole main user space, or both scratchpad sectors. Reads of the data register can be plain, can always launch a fetch for streaming, or can launch a fetch only once the last fetched byte has been taken.

Top module: `flash_indirect_ctrl`

## Requirements
- R1: After reset, control, address, data and status all read 0x00. Control byte layout: bit 7 scratchpad select, bits 6:4 write mode, bits 3:0 read mode. Status: bit 0 busy, bit 1 data-valid. Host select codes: 0 control, 1 address[7:0], 2 address[15:8], 3 address[16] in bit 0, 4 data, 5 status. Memory op codes: 0 read, 1 program, 2 page erase, 3 bulk erase.
- R2: Write mode 000: a data write only loads the data register and raises no memory request.
- R3: Write mode 001: a data write loads the data register and requests a program (op 1) of that byte at the current address. On the done pulse the address register increments by one.
- R4: Write mode 010: a data write loads the data register. Only when the byte is 0xA5 does it request a page erase (op 2) at the current address with the low page bits cleared (512-byte pages). The address register is left unchanged.
- R5: In the main array, an erase with the key at address 0x1FBFE or 0x1FBFF requests a bulk erase (op 3) with the scratchpad flag low, instead of a page erase.
- R6: With scratchpad select set, every request carries the scratchpad flag. A keyed erase at 0x400 requests a bulk erase (op 3). Page erases clear the low 7 bits. Any other access at an address of 0x100 or above raises no request.
- R7: Read mode 0000: a data read returns the held byte and raises no request.
- R8: Read mode 0001: a data read while idle requests a read (op 0) at the current address. The done pulse loads the returned byte into the data register, sets data-valid and increments the address.
- R9: Read mode 0010: a data read while idle requests a read only if data-valid is clear.
- R10: A data read made while idle clears data-valid.
- R11: Reserved write modes ignore data writes completely, and the data register keeps its value. Reserved read modes raise no request.
- R12: Data-register accesses made while busy are ignored. They neither change the data register nor raise a request.
- R13: A memory request lasts exactly one cycle. Busy rises together with it and stays set until the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 3 | Host register select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (applies side effects of data reads) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Selected register contents |
| mem_req | output | 1 | One-cycle memory request |
| mem_op | output | 2 | Operation code, held while busy |
| mem_addr | output | 17 | Operation address, held while busy |
| mem_scratch | output | 1 | Operation targets the scratchpad |
| mem_wdata | output | 8 | Byte to program, or erase key |
| mem_done | input | 1 | One-cycle completion pulse from memory |
| mem_rdata | input | 8 | Fetched byte, valid with mem_done on a read |

## Verification
The assertions assume that the memory answers each request with exactly one done pulse and never pulses done while idle. They also assume that the host does not rewrite the address register in the cycle a program completes, since the increment check compares against the previous address. The bench's memory model answers every request once, a fixed few cycles later. The bench leaves a gap of several idle cycles after every access, except in the one test that deliberately writes during busy, and it never writes the address while an operation is open.

// File: rtl/fic_pkg.sv
package fic_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_PROG   = 2'd1,
    OP_PERASE = 2'd2,
    OP_BULK   = 2'd3
  } mem_op_e;

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_AD0  = 3'd1;
  localparam logic [2:0] SEL_AD1  = 3'd2;
  localparam logic [2:0] SEL_AD2  = 3'd3;
  localparam logic [2:0] SEL_DATA = 3'd4;
  localparam logic [2:0] SEL_STAT = 3'd5;

  localparam logic [2:0] WM_HOLD  = 3'd0;
  localparam logic [2:0] WM_PROG  = 3'd1;
  localparam logic [2:0] WM_ERASE = 3'd2;

  localparam logic [3:0] RM_PLAIN  = 4'd0;
  localparam logic [3:0] RM_STREAM = 4'd1;
  localparam logic [3:0] RM_SINGLE = 4'd2;

  localparam logic [7:0] ERASE_KEY = 8'hA5;
endpackage

// File: rtl/fic_regs.sv
module fic_regs #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [2:0]        host_sel,
  input  logic [7:0]        host_wdata,
  input  logic              addr_inc,
  output logic [7:0]        ctrl_q,
  output logic [ADDR_W-1:0] addr_q
);
  import fic_pkg::*;

  logic [7:0]        ctrl_d;
  logic [ADDR_W-1:0] addr_d;
  logic [23:0]       addr_ext;

  always_comb begin
    ctrl_d   = ctrl_q;
    addr_ext = 24'(addr_q);
    if (addr_inc) addr_ext = 24'(addr_q + 1'b1);
    if (host_wr) begin
      case (host_sel)
        SEL_CTRL: ctrl_d          = host_wdata;
        SEL_AD0:  addr_ext[7:0]   = host_wdata;
        SEL_AD1:  addr_ext[15:8]  = host_wdata;
        SEL_AD2:  addr_ext[23:16] = host_wdata;
        default: ;
      endcase
    end
    addr_d = addr_ext[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      addr_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/fic_decode.sv
module fic_decode #(
  parameter int ADDR_W     = 17,
  parameter int PAGE_BYTES = 512,
  parameter int SECT_BYTES = 128,
  parameter int SCR_LIMIT  = 256,
  parameter int SCR_BULK   = 'h400,
  parameter int MAIN_BULK  = 'h1FBFE
) (
  input  logic              [7:0]        ctrl,
  input  logic              [ADDR_W-1:0] addr,
  input  logic              [7:0]        wdata,
  input  logic                           data_wr,
  input  logic                           data_rd,
  input  logic                           active,
  input  logic                           dvalid,
  output logic                           launch,
  output fic_pkg::mem_op_e               launch_op,
  output logic              [ADDR_W-1:0] launch_addr,
  output logic                           take_data,
  output logic                           clear_valid
);
  import fic_pkg::*;

  localparam logic [ADDR_W-1:0] MAIN_MASK = ~ADDR_W'(PAGE_BYTES - 1);
  localparam logic [ADDR_W-1:0] SECT_MASK = ~ADDR_W'(SECT_BYTES - 1);
  localparam logic [ADDR_W-1:0] BULK_A    = ADDR_W'(MAIN_BULK);
  localparam logic [ADDR_W-1:0] SBULK_A   = ADDR_W'(SCR_BULK);
  localparam logic [ADDR_W-1:0] SLIM_A    = ADDR_W'(SCR_LIMIT);

  logic       scr;
  logic [2:0] wmode;
  logic [3:0] rmode;
  logic       range_ok, main_bulk, scr_bulk;
  logic [ADDR_W-1:0] page_addr;

  assign scr       = ctrl[7];
  assign wmode     = ctrl[6:4];
  assign rmode     = ctrl[3:0];
  assign range_ok  = !scr || (addr < SLIM_A);
  assign main_bulk = !scr && (addr[ADDR_W-1:1] == BULK_A[ADDR_W-1:1]);
  assign scr_bulk  = scr && (addr == SBULK_A);
  assign page_addr = addr & (scr ? SECT_MASK : MAIN_MASK);

  always_comb begin
    launch      = 1'b0;
    launch_op   = OP_READ;
    launch_addr = addr;
    take_data   = 1'b0;
    clear_valid = 1'b0;
    if (data_wr && !active) begin
      case (wmode)
        WM_HOLD: take_data = 1'b1;
        WM_PROG: begin
          take_data = 1'b1;
          launch    = range_ok;
          launch_op = OP_PROG;
        end
        WM_ERASE: begin
          take_data = 1'b1;
          if (wdata == ERASE_KEY) begin
            if (main_bulk || scr_bulk) begin
              launch    = 1'b1;
              launch_op = OP_BULK;
            end else begin
              launch      = range_ok;
              launch_op   = OP_PERASE;
              launch_addr = page_addr;
            end
          end
        end
        default: ;
      endcase
    end else if (data_rd && !active) begin
      clear_valid = 1'b1;
      case (rmode)
        RM_STREAM: launch = range_ok;
        RM_SINGLE: launch = range_ok && !dvalid;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fic_track.sv
module fic_track #(
  parameter int ADDR_W = 17
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           launch,
  input  fic_pkg::mem_op_e               launch_op,
  input  logic              [ADDR_W-1:0] launch_addr,
  input  logic                           launch_scr,
  input  logic                           take_data,
  input  logic              [7:0]        host_wdata,
  input  logic                           clear_valid,
  input  logic                           mem_done,
  input  logic              [7:0]        mem_rdata,
  output logic                           active_q,
  output logic                           dvalid_q,
  output logic              [7:0]        data_q,
  output logic                           req_q,
  output fic_pkg::mem_op_e               op_q,
  output logic              [ADDR_W-1:0] maddr_q,
  output logic                           scr_q,
  output logic                           addr_inc
);
  import fic_pkg::*;

  logic              active_d, dvalid_d, req_d, scr_d, finish;
  logic [7:0]        data_d;
  mem_op_e           op_d;
  logic [ADDR_W-1:0] maddr_d;

  assign finish   = mem_done && active_q;
  assign addr_inc = finish && (op_q == OP_PROG || op_q == OP_READ);

  always_comb begin
    active_d = active_q;
    dvalid_d = dvalid_q;
    data_d   = data_q;
    req_d    = 1'b0;
    op_d     = op_q;
    maddr_d  = maddr_q;
    scr_d    = scr_q;
    if (take_data)   data_d   = host_wdata;
    if (clear_valid) dvalid_d = 1'b0;
    if (launch) begin
      active_d = 1'b1;
      req_d    = 1'b1;
      op_d     = launch_op;
      maddr_d  = launch_addr;
      scr_d    = launch_scr;
    end
    if (finish) begin
      active_d = 1'b0;
      if (op_q == OP_READ) begin
        data_d   = mem_rdata;
        dvalid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      dvalid_q <= 1'b0;
      data_q   <= '0;
      req_q    <= 1'b0;
      op_q     <= OP_READ;
      maddr_q  <= '0;
      scr_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      dvalid_q <= dvalid_d;
      data_q   <= data_d;
      req_q    <= req_d;
      op_q     <= op_d;
      maddr_q  <= maddr_d;
      scr_q    <= scr_d;
    end
  end
endmodule

// File: rtl/flash_indirect_ctrl.sv
module flash_indirect_ctrl #(
  parameter int ADDR_W     = 17,
  parameter int PAGE_BYTES = 512,
  parameter int SECT_BYTES = 128,
  parameter int SCR_LIMIT  = 256,
  parameter int SCR_BULK   = 'h400,
  parameter int MAIN_BULK  = 'h1FBFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              mem_req,
  output logic [1:0]        mem_op,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_scratch,
  output logic [7:0]        mem_wdata,
  input  logic              mem_done,
  input  logic [7:0]        mem_rdata
);
  import fic_pkg::*;

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [7:0]        ctrl_q, data_q;
  logic [ADDR_W-1:0] addr_q, launch_addr, maddr_q;
  logic [23:0]       addr_view;
  logic              data_wr, data_rd, launch, take_data, clear_valid;
  logic              op_active, dvalid_q, req_q, scr_q, addr_inc;
  mem_op_e           launch_op, op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign data_wr = host_wr && (host_sel == SEL_DATA);
  assign data_rd = host_rd && (host_sel == SEL_DATA);

  fic_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .addr_inc(addr_inc), .ctrl_q(ctrl_q), .addr_q(addr_q)
  );

  fic_decode #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .SECT_BYTES(SECT_BYTES),
    .SCR_LIMIT(SCR_LIMIT), .SCR_BULK(SCR_BULK), .MAIN_BULK(MAIN_BULK)
  ) u_decode (
    .ctrl(ctrl_q), .addr(addr_q), .wdata(host_wdata), .data_wr(data_wr),
    .data_rd(data_rd), .active(op_active), .dvalid(dvalid_q), .launch(launch),
    .launch_op(launch_op), .launch_addr(launch_addr), .take_data(take_data),
    .clear_valid(clear_valid)
  );

  fic_track #(.ADDR_W(ADDR_W)) u_track (
    .clk(clk), .rst_n(rst_int_n), .launch(launch), .launch_op(launch_op),
    .launch_addr(launch_addr), .launch_scr(ctrl_q[7]), .take_data(take_data),
    .host_wdata(host_wdata), .clear_valid(clear_valid), .mem_done(mem_done),
    .mem_rdata(mem_rdata), .active_q(op_active), .dvalid_q(dvalid_q),
    .data_q(data_q), .req_q(req_q), .op_q(op_q), .maddr_q(maddr_q),
    .scr_q(scr_q), .addr_inc(addr_inc)
  );

  assign addr_view   = 24'(addr_q);
  assign mem_req     = req_q;
  assign mem_op      = op_q;
  assign mem_addr    = maddr_q;
  assign mem_scratch = scr_q;
  assign mem_wdata   = data_q;

  always_comb begin
    case (host_sel)
      SEL_CTRL: host_rdata = ctrl_q;
      SEL_AD0:  host_rdata = addr_view[7:0];
      SEL_AD1:  host_rdata = addr_view[15:8];
      SEL_AD2:  host_rdata = addr_view[23:16];
      SEL_DATA: host_rdata = data_q;
      SEL_STAT: host_rdata = {6'b0, dvalid_q, op_active};
      default:  host_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/fic_checker.sv
module fic_checker #(
  parameter int ADDR_W    = 17,
  parameter int SCR_LIMIT = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic [1:0]        mem_op,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_scratch,
  input logic [7:0]        mem_wdata,
  input logic              mem_done,
  input logic              busy,
  input logic [ADDR_W-1:0] addr
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R13
  AST_BUSY_RISES_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_req); // R13
  AST_NO_REQ_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$rose(busy)) |-> !mem_req); // R12
  AST_ERASE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_op[1]) |-> (mem_wdata == 8'hA5)); // R4
  AST_PROG_STEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_done && mem_op == 2'd1) |=> (addr == $past(addr) + 1'b1)); // R3
  AST_ERASE_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_done && mem_op[1]) |=> $stable(addr)); // R4
  AST_SCR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_scratch && mem_op != 2'd3) |-> (mem_addr < ADDR_W'(SCR_LIMIT))); // R6
endmodule

bind flash_indirect_ctrl fic_checker #(.ADDR_W(ADDR_W), .SCR_LIMIT(SCR_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .mem_req(mem_req), .mem_op(mem_op),
  .mem_addr(mem_addr), .mem_scratch(mem_scratch), .mem_wdata(mem_wdata),
  .mem_done(mem_done), .busy(op_active), .addr(addr_q)
);

// File: tb/flash_indirect_ctrl_bench.sv
`timescale 1ns/1ps
module flash_indirect_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_sel = 3'd0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        mem_req, mem_scratch;
  logic [1:0]  mem_op;
  logic [16:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_done = 1'b0;
  logic [7:0]  mem_rdata = 8'h00;

  int n_chk = 0, n_bad = 0;
  int req_cnt = 0;
  int cd = 0;
  logic [1:0]  last_op = 2'd0;
  logic [16:0] last_addr = '0;
  logic        last_scr = 1'b0;
  logic [7:0]  last_wdata = 8'h00;

  always #10 clk = ~clk;

  flash_indirect_ctrl u_flash_indirect_ctrl (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr),
    .mem_scratch(mem_scratch), .mem_wdata(mem_wdata), .mem_done(mem_done),
    .mem_rdata(mem_rdata)
  );

  // memory model: one done pulse a few cycles after each request
  always @(posedge clk) begin
    mem_done <= (cd == 1);
    if (mem_req) begin
      cd         <= 3;
      req_cnt    <= req_cnt + 1;
      last_op    <= mem_op;
      last_addr  <= mem_addr;
      last_scr   <= mem_scratch;
      last_wdata <= mem_wdata;
      mem_rdata  <= mem_addr[7:0] ^ 8'hC3;
    end else if (cd != 0) begin
      cd <= cd - 1;
    end
  end

  typedef struct packed { logic rd; logic [2:0] sel; logic [7:0] val; } vec_t;
  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd0, 8'h00}, // R1 control after reset
    '{1'b1, 3'd5, 8'h00}, // R1 status after reset
    '{1'b0, 3'd4, 8'h5A}, // R2 hold mode write
    '{1'b1, 3'd4, 8'h5A}, // R7 plain read returns held byte
    '{1'b0, 3'd0, 8'h10},
    '{1'b0, 3'd1, 8'h20},
    '{1'b0, 3'd4, 8'h77}, // R3 program
    '{1'b1, 3'd1, 8'h21}, // R3 address stepped
    '{1'b0, 3'd4, 8'h78},
    '{1'b1, 3'd1, 8'h22}, // R3
    '{1'b0, 3'd0, 8'h20},
    '{1'b0, 3'd4, 8'h11}, // R4 no key
    '{1'b1, 3'd4, 8'h11}, // R4 data still loaded
    '{1'b0, 3'd4, 8'hA5}, // R4 keyed erase
    '{1'b1, 3'd1, 8'h22}, // R4 address kept
    '{1'b0, 3'd0, 8'h01},
    '{1'b1, 3'd4, 8'hA5}, // R8 launches fetch at 0x22
    '{1'b1, 3'd5, 8'h02}, // R8 data-valid set
    '{1'b1, 3'd4, 8'hE1}, // R8 fetched byte, next fetch
    '{1'b1, 3'd1, 8'h24}, // R8 address stepped twice
    '{1'b0, 3'd0, 8'h02},
    '{1'b1, 3'd4, 8'hE0}, // R9 valid set: no fetch
    '{1'b1, 3'd5, 8'h00}, // R10 valid cleared
    '{1'b1, 3'd1, 8'h24}, // R9 no fetch happened
    '{1'b1, 3'd4, 8'hE0}, // R9 valid clear: fetch
    '{1'b1, 3'd1, 8'h25}, // R9
    '{1'b1, 3'd4, 8'hE7},
    '{1'b0, 3'd0, 8'h07},
    '{1'b1, 3'd4, 8'hE7}, // R11 reserved read mode
    '{1'b1, 3'd1, 8'h25}, // R11 no fetch
    '{1'b0, 3'd0, 8'h30},
    '{1'b0, 3'd4, 8'h99}, // R11 reserved write mode
    '{1'b1, 3'd4, 8'hE7}  // R11 data kept
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] v);
    @(negedge clk); host_sel = s; host_wdata = v; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    @(negedge clk); host_sel = s; host_rd = 1'b1; #1 v = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_addr(input logic [16:0] a);
    wr(3'd1, a[7:0]); wr(3'd2, a[15:8]); wr(3'd3, {7'b0, a[16]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    chk("R1 mem_req idle", 32'(mem_req), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) begin
        rd(VEC[i].sel, v);
        chk($sformatf("table vec %0d", i), 32'(v), 32'(VEC[i].val));
      end else begin
        wr(VEC[i].sel, VEC[i].val);
      end
      idle(10);
    end

    // R2: hold mode raises no request
    wr(3'd0, 8'h00); c0 = req_cnt;
    wr(3'd4, 8'h3E); idle(10);
    chk("R2 no request", 32'(req_cnt - c0), 0);

    // R3 / R13 / R12: program request fields, pulse and busy
    wr(3'd0, 8'h10); set_addr(17'h12345); idle(2); c0 = req_cnt;
    wr(3'd4, 8'h5C);
    chk("R13 req high", 32'(mem_req), 1);
    host_sel = 3'd5; #1 chk("R13 busy set", 32'(host_rdata), 32'h01);
    @(negedge clk);
    chk("R13 req one cycle", 32'(mem_req), 0);
    wr(3'd4, 8'h66); // R12 while busy
    idle(10);
    chk("R12 one request", 32'(req_cnt - c0), 1);
    chk("R3 op", 32'(last_op), 1);
    chk("R3 addr", 32'(last_addr), 32'h12345);
    chk("R3 wdata", 32'(last_wdata), 32'h5C);
    rd(3'd4, v); chk("R12 data kept", 32'(v), 32'h5C);
    rd(3'd1, v); chk("R3 addr lo step", 32'(v), 32'h46);
    rd(3'd5, v); chk("R13 busy cleared", 32'(v), 32'h00);

    // R4: page-aligned erase, address kept
    wr(3'd0, 8'h20); set_addr(17'h12345);
    wr(3'd4, 8'hA5); idle(10);
    chk("R4 op", 32'(last_op), 2);
    chk("R4 page addr", 32'(last_addr), 32'h12200);
    rd(3'd1, v); chk("R4 addr kept", 32'(v), 32'h45);

    // R5: bulk erase addresses in main array
    set_addr(17'h1FBFE); wr(3'd4, 8'hA5); idle(10);
    chk("R5 bulk op FE", 32'(last_op), 3);
    chk("R5 main flag", 32'(last_scr), 0);
    set_addr(17'h1FBFF); wr(3'd4, 8'hA5); idle(10);
    chk("R5 bulk op FF", 32'(last_op), 3);
    set_addr(17'h1FBFD); wr(3'd4, 8'hA5); idle(10);
    chk("R5 neighbour is page erase", 32'(last_op), 2);
    chk("R5 neighbour page", 32'(last_addr), 32'h1FA00);

    // R6: scratchpad
    wr(3'd0, 8'hA0); set_addr(17'h00400); wr(3'd4, 8'hA5); idle(10);
    chk("R6 scratch bulk op", 32'(last_op), 3);
    chk("R6 scratch flag", 32'(last_scr), 1);
    set_addr(17'h000C5); wr(3'd4, 8'hA5); idle(10);
    chk("R6 sector erase op", 32'(last_op), 2);
    chk("R6 sector addr", 32'(last_addr), 32'h80);
    c0 = req_cnt;
    set_addr(17'h00123); wr(3'd4, 8'hA5); idle(10);
    wr(3'd0, 8'h90); set_addr(17'h00150); wr(3'd4, 8'h12); idle(10);
    chk("R6 out of range ignored", 32'(req_cnt - c0), 0);
    wr(3'd0, 8'h81); set_addr(17'h00010); rd(3'd4, v); idle(10);
    chk("R6 scratch read op", 32'(last_op), 0);
    chk("R6 scratch read flag", 32'(last_scr), 1);
    rd(3'd4, v); chk("R8 scratch read data", 32'(v), 32'hD3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule